// File: doc/BRIEF.md
# Buffer RAM Self-Test Controller with Readback Checksum

This block owns a dual-port byte-wide buffer RAM and exercises it. With the test-mode input high, a start pulse makes the filler write every location once, from address 0 upward, with a generated byte stream. Three generators are available: a seeded pseudo-random sequence, the address itself, and a rotating seed pattern. While it writes, the filler folds each byte into a 16-bit ones'-complement checksum. When the fill ends, that checksum is presented as the expected value.

A second engine reads the RAM back over an inclusive address window and produces the same kind of checksum from what it reads. Software lowers test mode, runs the readback over the whole RAM and compares the two sums. The test passes when they are equal. A port-select input swaps which RAM port the filler writes through and which port the readback uses, so each port can act as writer in one run and as reader in another.

Top module: `mbist_top`

## Requirements
- R1: After reset, `bistBusy` and `dmaBusy` are 0 and `bistSum` and `dmaSum` are 0x0000.
- R2: A `bistStart` pulse starts a fill only when `testEn` is 1 and both engines are idle. `bistBusy` then reads 1 for exactly DEPTH+1 cycles, starting the cycle after the pulse, and clears by itself. A pulse with `testEn` at 0 is ignored, and `bistSum` keeps its value.
- R3: A checksum pairs consecutive bytes into big-endian 16-bit words, with the first byte of each pair as the high byte. It adds the words with end-around carry, pads an odd trailing byte with a zero low byte, and presents the bitwise inverse of the sum.
- R4: Fill mode 2'b01 writes the low 8 bits of each address into that location. `bistSum` is then the R3 checksum of that content.
- R5: Fill mode 2'b00 loads an 8-bit LFSR from `seed`, or from 0x01 when `seed` is zero. It writes the current LFSR value at each address and steps once per write. A step shifts left and brings in bit7^bit5^bit4^bit3 at bit 0.
- R6: Fill mode 2'b10 writes `seed` rotated left by (address mod 8). Mode 2'b11 writes 0x00 everywhere.
- R7: A `dmaStart` pulse reads bytes from `dmaFirst` up to and including `dmaLast`, wrapping from DEPTH-1 to 0. `dmaBusy` reads 1 for the window length plus 2 cycles. After that, `dmaSum` holds the R3 checksum of the bytes in read order.
- R8: `dmaStart` is ignored while `testEn` is 1 or while the fill runs. `dmaBusy` stays 0 and `dmaSum` is unchanged.
- R9: `portSel`, sampled at fill start, swaps the filler and readback RAM ports. The stored content and both checksums are the same for either value.
- R10: A readback over 0..DEPTH-1 after any fill yields a `dmaSum` equal to `bistSum`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| testEn | input | 1 | Test-mode enable; required to launch a fill, blocks readback |
| bistStart | input | 1 | Fill launch pulse |
| fillMode | input | 2 | Generator select (00 random, 01 address, 10 rotate, 11 zero) |
| seed | input | 8 | Seed for random and rotate generators |
| portSel | input | 1 | Swap filler and readback RAM ports |
| dmaStart | input | 1 | Readback launch pulse |
| dmaFirst | input | AW | First readback address |
| dmaLast | input | AW | Last readback address (inclusive) |
| bistBusy | output | 1 | Fill in progress |
| dmaBusy | output | 1 | Readback in progress |
| bistSum | output | 16 | Checksum of the bytes written |
| dmaSum | output | 16 | Checksum of the bytes read back |

## Verification
The bench builds the block with DEPTH=64 (AW=6). At that size one fill takes 65 cycles, so every one of the 256 seeds of the random generator can be filled and read back in full, alternating the port selection between runs. The small depth also lets short, odd-length and wrapping readback windows be tested next to full-range ones. Expected sums come from an arithmetic model of the content and of the checksum rule.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [1:0] {
    FILL_RANDOM = 2'b00,
    FILL_ADDR   = 2'b01,
    FILL_ROTATE = 2'b10,
    FILL_ZERO   = 2'b11
  } fillMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic bistClr;
    logic fillWr;
    logic bistFin;
    logic dmaClr;
    logic dmaRd;
    logic dmaFin;
  } ctrlStb_t;

  // ones'-complement addition with end-around carry
  function automatic logic [15:0] onesAdd(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

endpackage

// File: rtl/mbist_ram.sv
module mbist_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we0,
  input  logic [AW-1:0] addr0,
  input  logic [7:0]    wd0,
  output logic [7:0]    rd0,
  input  logic          we1,
  input  logic [AW-1:0] addr1,
  input  logic [7:0]    wd1,
  output logic [7:0]    rd1
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we0) mem[addr0] <= wd0;
    if (we1) mem[addr1] <= wd1;
    rd0 <= mem[addr0];
    rd1 <= mem[addr1];
  end
endmodule

// File: rtl/mbist_csum.sv
module mbist_csum (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clr,
  input  logic        byteVld,
  input  logic [7:0]  byteIn,
  input  logic        fin,
  output logic [15:0] sum
);
  import mbist_pkg::*;

  logic [15:0] acc;
  logic [7:0]  hiByte;
  logic        pending;
  logic [15:0] closing;

  // fold in a zero-padded odd byte if one is waiting
  assign closing = pending ? onesAdd(acc, {hiByte, 8'h00}) : acc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      hiByte  <= '0;
      pending <= 1'b0;
      sum     <= '0;
    end else begin
      if (clr) begin
        acc     <= '0;
        pending <= 1'b0;
      end else if (byteVld) begin
        if (!pending) begin
          hiByte  <= byteIn;
          pending <= 1'b1;
        end else begin
          acc     <= onesAdd(acc, {hiByte, byteIn});
          pending <= 1'b0;
        end
      end
      if (fin) sum <= ~closing;
    end
  end
endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl #(
  parameter int AW = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               testEn,
  input  logic               bistStart,
  input  logic               dmaStart,
  input  logic [AW-1:0]      dmaFirst,
  input  logic [AW-1:0]      dmaLast,
  output mbist_pkg::ctrlStb_t stb,
  output logic [AW-1:0]      curAddr,
  output logic               bistBusy,
  output logic               dmaBusy
);
  typedef enum logic [2:0] {S_IDLE, S_FILL, S_BFIN, S_DRD, S_DWAIT, S_DFIN} state_e;

  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  state_e        state;
  logic [AW-1:0] lastQ;
  logic          idle;

  assign idle = (state == S_IDLE);

  always_comb begin
    stb         = '0;
    stb.bistClr = idle && bistStart && testEn;
    stb.dmaClr  = idle && dmaStart && !testEn;
    stb.fillWr  = (state == S_FILL);
    stb.bistFin = (state == S_BFIN);
    stb.dmaRd   = (state == S_DRD);
    stb.dmaFin  = (state == S_DFIN);
  end

  assign bistBusy = (state == S_FILL) || (state == S_BFIN);
  assign dmaBusy  = (state == S_DRD) || (state == S_DWAIT) || (state == S_DFIN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      curAddr <= '0;
      lastQ   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (stb.bistClr) begin
            state   <= S_FILL;
            curAddr <= '0;
          end else if (stb.dmaClr) begin
            state   <= S_DRD;
            curAddr <= dmaFirst;
            lastQ   <= dmaLast;
          end
        end
        S_FILL: begin
          curAddr <= curAddr + 1'b1;
          if (curAddr == TOP_ADDR) state <= S_BFIN;
        end
        S_BFIN: state <= S_IDLE;
        S_DRD: begin
          if (curAddr == lastQ) state <= S_DWAIT;
          else                  curAddr <= curAddr + 1'b1;
        end
        S_DWAIT: state <= S_DFIN;
        S_DFIN:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbist_dpath.sv
module mbist_dpath #(
  parameter int AW = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  mbist_pkg::ctrlStb_t stb,
  input  logic [AW-1:0]       curAddr,
  input  logic [1:0]          fillMode,
  input  logic [7:0]          seed,
  input  logic                portSel,
  output logic                we0,
  output logic [7:0]          wd0,
  input  logic [7:0]          rd0,
  output logic                we1,
  output logic [7:0]          wd1,
  input  logic [7:0]          rd1,
  output logic [15:0]         bistSum,
  output logic [15:0]         dmaSum
);
  import mbist_pkg::*;

  fillMode_e  modeQ;
  logic [7:0] seedQ;
  logic       swapQ;
  logic [7:0] lfsr;
  logic [7:0] fillByte;
  logic [15:0] rotPair;
  logic       rdVld;
  logic [7:0] rdByte;

  assign rotPair = {seedQ, seedQ} << curAddr[2:0];

  always_comb begin
    unique case (modeQ)
      FILL_RANDOM: fillByte = lfsr;
      FILL_ADDR:   fillByte = 8'(curAddr);
      FILL_ROTATE: fillByte = rotPair[15:8];
      default:     fillByte = 8'h00;
    endcase
  end

  // filler on port 0 unless swapped; readback on the other port
  assign we0    = stb.fillWr && !swapQ;
  assign we1    = stb.fillWr && swapQ;
  assign wd0    = fillByte;
  assign wd1    = fillByte;
  assign rdByte = swapQ ? rd0 : rd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= FILL_RANDOM;
      seedQ <= '0;
      swapQ <= 1'b0;
      lfsr  <= 8'h01;
      rdVld <= 1'b0;
    end else begin
      rdVld <= stb.dmaRd;
      if (stb.bistClr) begin
        modeQ <= fillMode_e'(fillMode);
        seedQ <= seed;
        swapQ <= portSel;
        lfsr  <= (seed == 8'h00) ? 8'h01 : seed;
      end else if (stb.fillWr) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
    end
  end

  mbist_csum u_bistSum (
    .clk(clk), .rstN(rstN), .clr(stb.bistClr), .byteVld(stb.fillWr),
    .byteIn(fillByte), .fin(stb.bistFin), .sum(bistSum)
  );

  mbist_csum u_dmaSum (
    .clk(clk), .rstN(rstN), .clr(stb.dmaClr), .byteVld(rdVld),
    .byteIn(rdByte), .fin(stb.dmaFin), .sum(dmaSum)
  );
endmodule

// File: rtl/mbist_top.sv
module mbist_top #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          testEn,
  input  logic          bistStart,
  input  logic [1:0]    fillMode,
  input  logic [7:0]    seed,
  input  logic          portSel,
  input  logic          dmaStart,
  input  logic [AW-1:0] dmaFirst,
  input  logic [AW-1:0] dmaLast,
  output logic          bistBusy,
  output logic          dmaBusy,
  output logic [15:0]   bistSum,
  output logic [15:0]   dmaSum
);
  mbist_pkg::ctrlStb_t stb;
  logic [AW-1:0] curAddr;
  logic          we0, we1;
  logic [7:0]    wd0, wd1, rd0, rd1;

  mbist_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .testEn(testEn), .bistStart(bistStart),
    .dmaStart(dmaStart), .dmaFirst(dmaFirst), .dmaLast(dmaLast),
    .stb(stb), .curAddr(curAddr), .bistBusy(bistBusy), .dmaBusy(dmaBusy)
  );

  mbist_dpath #(.AW(AW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .curAddr(curAddr),
    .fillMode(fillMode), .seed(seed), .portSel(portSel),
    .we0(we0), .wd0(wd0), .rd0(rd0), .we1(we1), .wd1(wd1), .rd1(rd1),
    .bistSum(bistSum), .dmaSum(dmaSum)
  );

  mbist_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk),
    .we0(we0), .addr0(curAddr), .wd0(wd0), .rd0(rd0),
    .we1(we1), .addr1(curAddr), .wd1(wd1), .rd1(rd1)
  );
endmodule

// File: rtl/mbist_top_chk.sv
module mbist_top_chk (
  input logic        clk,
  input logic        rstN,
  input logic        testEn,
  input logic        bistStart,
  input logic        dmaStart,
  input logic        bistBusy,
  input logic        dmaBusy,
  input logic [15:0] bistSum,
  input logic [15:0] dmaSum
);
  a_r2_start_launches: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && bistStart && !bistBusy && !dmaBusy) |=> bistBusy);

  a_r2_start_needs_testen: assert property (@(posedge clk) disable iff (!rstN)
    (!testEn && bistStart && !bistBusy && !dmaBusy) |=> !bistBusy);

  a_r8_dma_blocked_in_test: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && !bistBusy && !dmaBusy) |=> !dmaBusy);

  a_r8_engines_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(bistBusy && dmaBusy));

  a_r3_bist_sum_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!bistBusy && !$past(bistBusy)) |-> $stable(bistSum));

  a_r7_dma_sum_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaBusy && !$past(dmaBusy)) |-> $stable(dmaSum));
endmodule

bind mbist_top mbist_top_chk u_chk (
  .clk(clk), .rstN(rstN), .testEn(testEn), .bistStart(bistStart),
  .dmaStart(dmaStart), .bistBusy(bistBusy), .dmaBusy(dmaBusy),
  .bistSum(bistSum), .dmaSum(dmaSum)
);

// File: tb/mbist_top_tb.sv
module mbist_top_tb;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          testEn = 1'b0;
  logic          bistStart = 1'b0;
  logic [1:0]    fillMode = 2'b00;
  logic [7:0]    seed = 8'h00;
  logic          portSel = 1'b0;
  logic          dmaStart = 1'b0;
  logic [AW-1:0] dmaFirst = '0;
  logic [AW-1:0] dmaLast = '0;
  logic          bistBusy, dmaBusy;
  logic [15:0]   bistSum, dmaSum;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [DEPTH];

  always #2 clk = ~clk;

  mbist_top #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .testEn(testEn), .bistStart(bistStart),
    .fillMode(fillMode), .seed(seed), .portSel(portSel),
    .dmaStart(dmaStart), .dmaFirst(dmaFirst), .dmaLast(dmaLast),
    .bistBusy(bistBusy), .dmaBusy(dmaBusy), .bistSum(bistSum), .dmaSum(dmaSum)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected RAM content from the generator rules
  task automatic buildModel(input logic [1:0] m, input logic [7:0] s);
    logic [7:0] r;
    r = (s == 8'h00) ? 8'h01 : s;
    for (int i = 0; i < DEPTH; i++) begin
      case (m)
        2'b00: model[i] = r;
        2'b01: model[i] = 8'(i);
        2'b10: model[i] = 8'((({8'h00, s} << (i % 8)) | ({8'h00, s} >> (8 - (i % 8)))) & 16'h00FF);
        default: model[i] = 8'h00;
      endcase
      r = {r[6:0], r[7] ^ r[5] ^ r[4] ^ r[3]};
    end
  endtask

  function automatic logic [15:0] refSum(input int first, input int last);
    logic [31:0] acc;
    logic [7:0]  hi;
    bit          half;
    int          idx;
    acc = 0; half = 0; idx = first;
    for (int n = 0; n < DEPTH; n++) begin
      if (!half) begin hi = model[idx]; half = 1; end
      else begin
        acc = acc + {16'd0, hi, model[idx]};
        acc = (acc & 32'hFFFF) + (acc >> 16);
        half = 0;
      end
      if (idx == last) break;
      idx = (idx + 1) % DEPTH;
    end
    if (half) begin
      acc = acc + {16'd0, hi, 8'h00};
      acc = (acc & 32'hFFFF) + (acc >> 16);
    end
    return ~acc[15:0];
  endfunction

  task automatic runBist(input logic [1:0] m, input logic [7:0] s, input logic ps, output int cyc);
    @(negedge clk);
    testEn = 1'b1; fillMode = m; seed = s; portSel = ps; bistStart = 1'b1;
    @(negedge clk);
    bistStart = 1'b0;
    cyc = 0;
    while (bistBusy) begin cyc++; @(negedge clk); end
  endtask

  task automatic runDma(input int first, input int last, output int cyc);
    @(negedge clk);
    testEn = 1'b0; dmaFirst = AW'(first); dmaLast = AW'(last); dmaStart = 1'b1;
    @(negedge clk);
    dmaStart = 1'b0;
    cyc = 0;
    while (dmaBusy) begin cyc++; @(negedge clk); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 bistBusy", bistBusy, 0);
    check("R1 dmaBusy", dmaBusy, 0);
    check("R1 bistSum", bistSum, 0);
    check("R1 dmaSum", dmaSum, 0);

    // R2: start without test mode is ignored
    testEn = 1'b0; fillMode = 2'b01; bistStart = 1'b1;
    @(negedge clk); bistStart = 1'b0;
    check("R2 ignored start busy", bistBusy, 0);
    repeat (2) @(negedge clk);
    check("R2 ignored start sum", bistSum, 0);

    // R4 address fill on each port selection, R9/R10 readback
    for (int ps = 0; ps < 2; ps++) begin
      buildModel(2'b01, 8'h00);
      runBist(2'b01, 8'h00, ps[0], cyc);
      check("R2 fill busy length", cyc, DEPTH + 1);
      check("R4 address fill sum", bistSum, refSum(0, DEPTH - 1));
      runDma(0, DEPTH - 1, cyc);
      check("R7 full readback busy length", cyc, DEPTH + 2);
      check("R10 dma equals bist", dmaSum, bistSum);
      check("R9 port swap readback", dmaSum, refSum(0, DEPTH - 1));
    end

    // R7/R3 windows: single byte, even, odd, wrap
    runDma(0, 0, cyc);
    check("R7 single byte len", cyc, 3);
    check("R3 odd pad single", dmaSum, refSum(0, 0));
    runDma(5, 6, cyc);
    check("R3 pair", dmaSum, refSum(5, 6));
    runDma(3, 11, cyc);
    check("R7 odd window len", cyc, 11);
    check("R3 odd window", dmaSum, refSum(3, 11));
    runDma(60, 3, cyc);
    check("R7 wrap len", cyc, 10);
    check("R7 wrap sum", dmaSum, refSum(60, 3));

    // R8: readback blocked in test mode
    held = dmaSum;
    @(negedge clk);
    testEn = 1'b1; dmaStart = 1'b1;
    @(negedge clk); dmaStart = 1'b0;
    check("R8 test mode blocks busy", dmaBusy, 0);
    repeat (2) @(negedge clk);
    check("R8 test mode keeps sum", dmaSum, held);

    // R8: readback blocked while fill runs
    buildModel(2'b10, 8'hA5);
    @(negedge clk);
    testEn = 1'b1; fillMode = 2'b10; seed = 8'hA5; portSel = 1'b0; bistStart = 1'b1;
    @(negedge clk);
    bistStart = 1'b0; testEn = 1'b0; dmaStart = 1'b1;
    @(negedge clk);
    dmaStart = 1'b0;
    check("R8 fill blocks readback", dmaBusy, 0);
    while (bistBusy) @(negedge clk);
    @(negedge clk);
    check("R8 no readback after fill", dmaBusy, 0);
    check("R8 sum unchanged", dmaSum, held);
    check("R6 rotate sum", bistSum, refSum(0, DEPTH - 1));

    // R6 rotate sweep and zero mode
    for (int s = 1; s < 256; s += 37) begin
      buildModel(2'b10, 8'(s));
      runBist(2'b10, 8'(s), s[0], cyc);
      check("R6 rotate seed sum", bistSum, refSum(0, DEPTH - 1));
      runDma(0, DEPTH - 1, cyc);
      check("R6 rotate readback", dmaSum, refSum(0, DEPTH - 1));
    end
    buildModel(2'b11, 8'h5A);
    runBist(2'b11, 8'h5A, 1'b1, cyc);
    check("R6 zero mode sum", bistSum, 16'hFFFF);
    runDma(7, 20, cyc);
    check("R6 zero mode readback", dmaSum, 16'hFFFF);

    // R5 every seed of random fill, ports alternating
    for (int s = 0; s < 256; s++) begin
      buildModel(2'b00, 8'(s));
      runBist(2'b00, 8'(s), s[0], cyc);
      check("R5 random fill sum", bistSum, refSum(0, DEPTH - 1));
      runDma(0, DEPTH - 1, cyc);
      check("R10 random readback match", dmaSum, bistSum);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule